// File: doc/BRIEF.md
# Peripheral Module Standby Controller

This block controls power-down for up to eleven on-chip peripherals. Software sets bits in two byte-wide control registers, one bit per peripheral. A peripheral whose bit is set is halted, with three effects:

- its clock enable drops;
- a synchronous reset is held on its registers;
- its interrupt request is masked.

The halt takes effect only at the next bus-cycle boundary after the control write. The boundary is marked by a strobe input.

The controller also sits in the register access path of every peripheral. A read from a halted peripheral's window returns 0xFF, and a write to it is dropped. Because the peripheral is held in reset for the whole halt, releasing it does not bring back its earlier contents. It comes back with reset values and must be programmed again.

Each peripheral is represented by a small stand-in register file so the behaviour can be observed at the ports. A parameter table assigns each standby bit to an address window.

Top module: `periph_standby_ctrl`

## Requirements
- R1: After reset all eleven standby bits are 0. Every module is active, the high control register reads 0xF8 and the low control register reads 0x00.
- R2: The control registers sit in window 15, where window = bus_addr[7:4]. Offset 0 (bus_addr[3:0]) is the high register: bits 2..0 hold standby bits 10..8, and bits 7..3 read as 1 and ignore writes. Offset 1 is the low register and holds standby bits 7..0. Any other offset in window 15 reads 0x00.
- R3: mod_halt changes only at a clock edge where cyc_start is 1. At that edge it loads the standby bits as they stood before the edge, so a write made in the same cycle takes effect at the following boundary. Releasing a halt follows the same rule.
- R4: A read (bus_sel=1, bus_we=0) in the window of a halted module returns 0xFF on bus_rdata one cycle after the access.
- R5: A write to the window of a halted module changes none of its registers.
- R6: While halted, a module's registers are held at their reset values. After release they read {window[3:0], 2'b00, offset[1:0]} until written again.
- R7: mod_irq of a module is 0 while it is halted, and is still 0 on the cycle it is released.
- R8: mod_clk_en is the inverse of mod_halt, and mod_rst equals mod_halt, at every cycle.
- R9: The control registers stay readable and writable whatever the standby state of the modules.
- R10: Standby bit k maps to the window in BIT_WIN[4k+3:4k], and by default bit k maps to window k. Windows 11 to 14 are unmapped: they read 0x00 and ignore writes.
- R11: Each active module has four byte registers at offsets 0..3, selected by bus_addr[1:0]. They can be written and read back, and bit 0 of register 0 drives that module's interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Marks the first clock of a bus cycle |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Window in [7:4], offset in [3:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after a read |
| mod_halt | output | 11 | Per-module halt state |
| mod_clk_en | output | 11 | Per-module clock enable |
| mod_rst | output | 11 | Per-module synchronous register reset |
| mod_irq | output | 11 | Per-module masked interrupt request |

## Verification
Several properties are checked on every cycle by the assertions:

- the halt vector moves only at bus-cycle boundaries, and then loads the standby bits held just before;
- clock enables stay complementary to the halt vector;
- reads of a halted window return 0xFF;
- interrupts stay clear on release.

Other properties only the bench scenarios can show, because they need history across many accesses. These are that writes to a halted module are lost, and that register contents come back as reset values after release rather than the values written earlier. The random mix, checked against a reference model, also shows that the high register's unused bits read as 1, and that control access is unaffected by any standby pattern.

// File: rtl/periph_stby_pkg.sv
package periph_stby_pkg;

  localparam int DATA_W = 8;
  localparam int WIN_IDX_W = 4;

  // Reset value of stand-in register `off` in module `idx`
  function automatic logic [DATA_W-1:0] stub_rst_val(input int idx, input int off);
    return {4'(idx), 2'b00, 2'(off)};
  endfunction

  // Identity map: standby bit k -> window k
  function automatic logic [63:0] ident_map();
    logic [63:0] m;
    for (int i = 0; i < 16; i++) m[i*4 +: 4] = 4'(i);
    return m;
  endfunction

endpackage

// File: rtl/stby_regs.sv
module stby_regs #(
  parameter int NUM_MOD = 11,
  localparam int HI_BITS = NUM_MOD - 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_start,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [7:0]         wdata,
  output logic [NUM_MOD-1:0] stby_q,
  output logic [NUM_MOD-1:0] halt_q,
  output logic [NUM_MOD-1:0] clk_en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_q <= '0;
    end else begin
      if (wr_hi) stby_q[NUM_MOD-1:8] <= wdata[HI_BITS-1:0];
      if (wr_lo) stby_q[7:0]         <= wdata;
    end
  end

  // Halt follows the standby bits only at bus-cycle boundaries
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q   <= '0;
      clk_en_q <= '1;
    end else if (cyc_start) begin
      halt_q   <= stby_q;
      clk_en_q <= ~stby_q;
    end
  end

endmodule

// File: rtl/mod_stub.sv
module mod_stub import periph_stby_pkg::*; #(
  parameter int IDX  = 0,
  parameter int NREG = 4,
  localparam int OFF_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int r = 0; r < NREG; r++) regs[r] <= stub_rst_val(IDX, r);
    end else if (en && wr) begin
      regs[off] <= wdata;
    end
  end

  assign rdata = regs[off];
  assign irq   = regs[0][0];

endmodule

// File: rtl/periph_standby_ctrl.sv
module periph_standby_ctrl import periph_stby_pkg::*; #(
  parameter int          NUM_MOD  = 11,
  parameter int          ADDR_W   = 8,
  parameter int          NREG     = 4,
  parameter logic [3:0]  CTRL_WIN = 4'hF,
  parameter logic [63:0] BIT_WIN  = ident_map()
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_start,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NUM_MOD-1:0] mod_halt,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst,
  output logic [NUM_MOD-1:0] mod_irq
);

  localparam int WIN_LSB = ADDR_W - WIN_IDX_W;
  localparam int OFF_W   = $clog2(NREG);
  localparam int HI_BITS = NUM_MOD - 8;

  logic [WIN_IDX_W-1:0] win;
  logic [WIN_LSB-1:0]   off;
  logic                 ctrl_hit, wr_hi, wr_lo;
  logic [NUM_MOD-1:0]   hit, halt, clk_en, stby, stub_irq;
  logic [7:0]           stub_rd [NUM_MOD];
  logic [7:0]           rd_next;

  assign win      = bus_addr[ADDR_W-1:WIN_LSB];
  assign off      = bus_addr[WIN_LSB-1:0];
  assign ctrl_hit = (win == CTRL_WIN);
  assign wr_hi    = bus_sel && bus_we && ctrl_hit && (off == 0);
  assign wr_lo    = bus_sel && bus_we && ctrl_hit && (off == 1);

  always_comb begin
    for (int k = 0; k < NUM_MOD; k++)
      hit[k] = !ctrl_hit && (win == BIT_WIN[k*4 +: 4]);
  end

  stby_regs #(.NUM_MOD(NUM_MOD)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cyc_start(cyc_start),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .wdata    (bus_wdata),
    .stby_q   (stby),
    .halt_q   (halt),
    .clk_en_q (clk_en)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    mod_stub #(.IDX(g), .NREG(NREG)) u_stub (
      .clk  (clk),
      .rst  (rst),
      .clr  (halt[g]),
      .en   (clk_en[g]),
      .wr   (bus_sel && bus_we && hit[g] && !halt[g]),
      .off  (off[OFF_W-1:0]),
      .wdata(bus_wdata),
      .rdata(stub_rd[g]),
      .irq  (stub_irq[g])
    );
  end

  // Read path: control bytes, intercepted windows, active stubs
  always_comb begin
    rd_next = 8'h00;
    if (ctrl_hit) begin
      if (off == 0)      rd_next = {{(8-HI_BITS){1'b1}}, stby[NUM_MOD-1:8]};
      else if (off == 1) rd_next = stby[7:0];
    end else begin
      for (int k = 0; k < NUM_MOD; k++)
        if (hit[k]) rd_next = halt[k] ? 8'hFF : stub_rd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= 8'h00;
    else if (bus_sel && !bus_we) bus_rdata <= rd_next;
  end

  assign mod_halt   = halt;
  assign mod_rst    = halt;
  assign mod_clk_en = clk_en;
  assign mod_irq    = stub_irq & ~halt;

endmodule

// File: rtl/periph_standby_chk.sv
module periph_standby_chk #(
  parameter int          NUM_MOD  = 11,
  parameter int          ADDR_W   = 8,
  parameter logic [3:0]  CTRL_WIN = 4'hF,
  parameter logic [63:0] BIT_WIN  = 64'h0
) (
  input logic               clk,
  input logic               rst,
  input logic               cyc_start,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [7:0]         bus_rdata,
  input logic [NUM_MOD-1:0] stby,
  input logic [NUM_MOD-1:0] mod_halt,
  input logic [NUM_MOD-1:0] mod_clk_en,
  input logic [NUM_MOD-1:0] mod_irq
);

  logic halted_hit;
  always_comb begin
    halted_hit = 1'b0;
    for (int k = 0; k < NUM_MOD; k++)
      if (bus_addr[ADDR_W-1 -: 4] != CTRL_WIN &&
          bus_addr[ADDR_W-1 -: 4] == BIT_WIN[k*4 +: 4] && mod_halt[k])
        halted_hit = 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (mod_halt == '0 && stby == '0)); // R1

  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_start) |-> $stable(mod_halt)); // R3

  AST_HALT_LOADS_STBY: assert property (@(posedge clk) disable iff (rst)
    $past(cyc_start && !rst) |-> mod_halt == $past(stby)); // R3

  AST_HALTED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_sel && !bus_we && halted_hit) |-> bus_rdata == 8'hFF); // R4

  AST_IRQ_CLEAR_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($past(mod_halt) & ~mod_halt & mod_irq) == '0); // R7

  AST_CLKEN_INVERSE: assert property (@(posedge clk) disable iff (rst)
    mod_clk_en == ~mod_halt); // R8

endmodule

bind periph_standby_ctrl periph_standby_chk #(
  .NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .CTRL_WIN(CTRL_WIN), .BIT_WIN(BIT_WIN)
) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .stby(stby), .mod_halt(mod_halt),
  .mod_clk_en(mod_clk_en), .mod_irq(mod_irq)
);

// File: tb/periph_standby_ctrl_tb_top.sv
module periph_standby_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc_start = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0, bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NM-1:0] mod_halt, mod_clk_en, mod_rst, mod_irq;

  int  n_checks = 0, n_errors = 0;
  bit  done = 1'b0;

  logic [NM-1:0] stby_m, halt_m;
  logic [7:0]    regs_m [NM][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_standby_ctrl dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_halt(mod_halt), .mod_clk_en(mod_clk_en), .mod_rst(mod_rst), .mod_irq(mod_irq)
  );

  function automatic logic [7:0] rst_val(int m, int o);
    return {4'(m), 2'b00, 2'(o)};
  endfunction

  function automatic logic [NM-1:0] irq_exp();
    logic [NM-1:0] v;
    for (int k = 0; k < NM; k++) v[k] = regs_m[k][0][0] & ~halt_m[k];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    stby_m = '0;
    halt_m = '0;
    for (int k = 0; k < NM; k++)
      for (int o = 0; o < 4; o++) regs_m[k][o] = rst_val(k, o);
  endtask

  // One clock of bus activity; called and returns at a falling edge
  task automatic step(bit sel, bit we, logic [7:0] addr, logic [7:0] wd, bit cyc);
    logic [3:0]    win;
    logic [3:0]    off;
    logic [7:0]    exp_rd;
    logic [NM-1:0] stby_old;
    string         tag;
    bit            is_rd;
    win = addr[7:4];
    off = addr[3:0];
    is_rd = sel && !we;
    exp_rd = 8'h00;
    tag = "R10";
    if (win == 4'hF) begin
      tag = "R2";
      if (off == 0)      exp_rd = {5'h1F, stby_m[10:8]};
      else if (off == 1) exp_rd = stby_m[7:0];
    end else if (win < NM) begin
      if (halt_m[win]) begin
        exp_rd = 8'hFF;
        tag = "R4";
      end else begin
        exp_rd = regs_m[win][off[1:0]];
        tag = "R11/R6/R5";
      end
    end
    cyc_start = cyc; bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    stby_old = stby_m;
    for (int k = 0; k < NM; k++)
      if (halt_m[k]) for (int o = 0; o < 4; o++) regs_m[k][o] = rst_val(k, o);
    if (sel && we) begin
      if (win == 4'hF && off == 0)      stby_m[10:8] = wd[2:0];
      else if (win == 4'hF && off == 1) stby_m[7:0] = wd;
      else if (win < NM && !halt_m[win]) regs_m[win][off[1:0]] = wd;
    end
    if (cyc) halt_m = stby_old;
    @(negedge clk);
    cyc_start = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    if (is_rd) chk(bus_rdata == exp_rd, tag, bus_rdata, exp_rd);
    chk(mod_halt == halt_m, "R3", mod_halt, halt_m);
    chk(mod_clk_en == ~halt_m && mod_rst == halt_m, "R8", {mod_clk_en, mod_rst},
        {~halt_m, halt_m});
    chk(mod_irq == irq_exp(), "R7", mod_irq, irq_exp());
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(mod_halt == '0 && mod_clk_en == '1, "R1", mod_halt, 0);
    step(1, 0, 8'hF0, 0, 1);  // R1 high reads F8
    chk(bus_rdata == 8'hF8, "R1", bus_rdata, 8'hF8);
    step(1, 0, 8'hF1, 0, 0);
    chk(bus_rdata == 8'h00, "R1", bus_rdata, 8'h00);

    // R11: program module 2, module 3 irq
    step(1, 1, 8'h21, 8'h5A, 1);
    step(1, 0, 8'h21, 0, 0);
    step(1, 1, 8'h30, 8'h01, 1);
    chk(mod_irq[3] == 1'b1, "R11", mod_irq[3], 1);

    // R3: halt request in the same cycle as a boundary waits a boundary
    step(1, 1, 8'hF1, 8'h0C, 1);
    chk(mod_halt[2] == 1'b0, "R3", mod_halt[2], 0);
    step(0, 0, 0, 0, 0);
    chk(mod_halt[2] == 1'b0, "R3", mod_halt[2], 0);
    step(0, 0, 0, 0, 1);
    chk(mod_halt[2] && mod_halt[3], "R3", mod_halt, 12);
    chk(mod_irq[3] == 1'b0, "R7", mod_irq[3], 0);

    // R4/R5: halted access
    step(1, 1, 8'h21, 8'h33, 1);
    step(1, 0, 8'h21, 0, 0);
    chk(bus_rdata == 8'hFF, "R4", bus_rdata, 8'hFF);

    // R9: control access while halted, incl. high register unused bits
    step(1, 1, 8'hF0, 8'hFF, 0);
    step(1, 0, 8'hF0, 0, 0);
    chk(bus_rdata == 8'hFF, "R9", bus_rdata, 8'hFF);
    step(1, 1, 8'hF0, 8'h00, 1);
    step(1, 1, 8'hF1, 8'h00, 0);
    step(0, 0, 0, 0, 1);
    chk(mod_halt == '0, "R3", mod_halt, 0);

    // R6/R5: contents after release are reset values
    step(1, 0, 8'h21, 0, 1);
    chk(bus_rdata == 8'h21, "R6", bus_rdata, 8'h21);
    step(1, 0, 8'h30, 0, 0);
    chk(bus_rdata == 8'h30, "R6", bus_rdata, 8'h30);

    // R10: unmapped window
    step(1, 1, 8'hB2, 8'h77, 1);
    step(1, 0, 8'hB2, 0, 0);
    chk(bus_rdata == 8'h00, "R10", bus_rdata, 8'h00);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [3:0] w;
      w = ($urandom % 4 == 0) ? 4'hF : 4'($urandom % 16);
      a = {w, 4'($urandom % 4)};
      step(($urandom % 10) < 7, $urandom % 2, a, 8'($urandom), ($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule